// File: doc/BRIEF.md
# PLL Lock Event Interrupt Controller

This block watches the lock indicators of three PLLs: a main PLL, a peripheral PLL and a memory PLL. It records each change of lock in a sticky flag and raises one combined interrupt line. Each PLL has two sticky conditions. One records that the PLL gained lock. The other records that the PLL lost lock. Each condition stays set until software clears it. A per-condition enable mask selects which conditions drive the interrupt.

Software reaches the block through four plain ports. An enable-set port only turns enables on. An enable-clear port only turns enables off. A status-clear port clears only the condition bits named in its mask. A read side shows the status word, the enable word and the present lock level of each PLL. The lock inputs are asynchronous to the block clock, so each one passes through a synchronizer before any edge is detected.

Top module: `pll_lock_irq`

## Requirements
- R1: While reset is asserted and directly after it, the status word, the enable word, the synchronized lock levels and the interrupt output are all zero.
- R2: `lockNow[i]` follows `lockIn[i]` with a delay of exactly two clock edges.
- R3: Status bit i (0 = main, 1 = peripheral, 2 = memory) sets when the synchronized lock of PLL i goes from 0 to 1. It then stays set even if lock drops again. A PLL that is already locked when reset is released counts as gaining lock.
- R4: Status bit 3+i sets when the synchronized lock of PLL i goes from 1 to 0. It then stays set.
- R5: When `enSetValid` is high, every enable bit that has a one in `enSetMask` becomes 1 at the next edge, and the other enable bits keep their value. When `enSetValid` is low, the mask has no effect.
- R6: When `enClrValid` is high, every enable bit that has a one in `enClrMask` becomes 0 at the next edge, and the other enable bits keep their value. If a set and a clear name the same bit in one cycle, the clear wins.
- R7: When `statClrValid` is high, every status bit that has a one in `statClrMask` is cleared at the next edge, and the other status bits keep their value. If a new event and a clear hit the same bit in one cycle, the bit stays set. When `statClrValid` is low, the mask has no effect.
- R8: `irqOut` is high exactly when at least one status bit is set whose enable bit is also set. It follows the registered status and enable words with no added delay.
- R9: A lock event shows in the status word at the edge after the one where `lockNow` changes. That is three edges after the change on `lockIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockIn | input | 3 | Raw asynchronous lock indicators: bit 0 main, bit 1 peripheral, bit 2 memory |
| enSetValid | input | 1 | Strobe for an enable-set operation |
| enSetMask | input | 6 | Enable bits to turn on |
| enClrValid | input | 1 | Strobe for an enable-clear operation |
| enClrMask | input | 6 | Enable bits to turn off |
| statClrValid | input | 1 | Strobe for a status clear |
| statClrMask | input | 6 | Status bits to clear |
| statusOut | output | 6 | Sticky conditions: bits 2..0 gained lock, bits 5..3 lost lock |
| enableOut | output | 6 | Enable mask, with the same bit layout as the status word |
| lockNow | output | 3 | Synchronized present lock level of each PLL |
| irqOut | output | 1 | Combined interrupt |

## Verification
Suppose the edge detector loses a transition or raises a spurious one. The wrong bit then shows in `statusOut` three edges after `lockIn` moves, and `irqOut` shows the same error whenever that bit is enabled. Suppose a mask operation touches the wrong bits. Then `enableOut` or `statusOut` is wrong at the very next edge. For that reason the stimulus combines masks with mixed ones and zeros, collisions of set and clear in one cycle, and an event that lands in the same cycle as a clear. Each cycle is compared against a model of the next-state rules.

// File: rtl/pll_irq_pkg.sv
package pll_irq_pkg;
  localparam int unsigned PLL_CNT = 3;
  localparam int unsigned COND_W  = 2 * PLL_CNT;

  typedef logic [COND_W-1:0] cond_t;

  // Strobes that the control half hands to the register half.
  typedef struct packed {
    cond_t statSet;
    cond_t statClr;
    cond_t enSet;
    cond_t enClr;
  } strobe_t;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : gChain
    logic [STAGES-1:0] chainQ;
    always_ff @(posedge clk) begin
      if (!rstN) chainQ <= '0;
      else       chainQ <= {chainQ[STAGES-2:0], asyncIn[i]};
    end
    assign syncOut[i] = chainQ[LAST];
  end
endmodule

// File: rtl/pll_irq_ctrl.sv
module pll_irq_ctrl
  import pll_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [PLL_CNT-1:0] lockSync,
  input  logic               enSetValid,
  input  cond_t              enSetMask,
  input  logic               enClrValid,
  input  cond_t              enClrMask,
  input  logic               statClrValid,
  input  cond_t              statClrMask,
  output strobe_t            strobes
);
  logic [PLL_CNT-1:0] prevLockQ;
  logic [PLL_CNT-1:0] riseEv;
  logic [PLL_CNT-1:0] fallEv;

  always_ff @(posedge clk) begin
    if (!rstN) prevLockQ <= '0;
    else       prevLockQ <= lockSync;
  end

  assign riseEv = lockSync & ~prevLockQ;
  assign fallEv = ~lockSync & prevLockQ;

  always_comb begin
    strobes.statSet = {fallEv, riseEv};
    strobes.statClr = statClrValid ? statClrMask : '0;
    strobes.enSet   = enSetValid   ? enSetMask   : '0;
    strobes.enClr   = enClrValid   ? enClrMask   : '0;
  end
endmodule

// File: rtl/pll_irq_datapath.sv
module pll_irq_datapath
  import pll_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobes,
  output cond_t   statusQ,
  output cond_t   enableQ,
  output logic    irqOut
);
  logic armQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      armQ    <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~strobes.statClr) | strobes.statSet;
      enableQ <= (enableQ | strobes.enSet) & ~strobes.enClr;
      armQ    <= 1'b1;
    end
  end

  assign irqOut = |(statusQ & enableQ);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> ((~statusQ & $past(statusQ) & ~$past(strobes.statClr)) == '0)); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> ((statusQ & $past(strobes.statSet)) == $past(strobes.statSet))); // R7
  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> ((enableQ & $past(strobes.enSet & ~strobes.enClr)) == $past(strobes.enSet & ~strobes.enClr))); // R5
  AST_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> ((enableQ & $past(strobes.enClr)) == '0)); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ != '0 && enableQ != '0)); // R8
endmodule

// File: rtl/pll_lock_irq.sv
module pll_lock_irq
  import pll_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PLL_CNT-1:0] lockIn,
  input  logic               enSetValid,
  input  logic [COND_W-1:0]  enSetMask,
  input  logic               enClrValid,
  input  logic [COND_W-1:0]  enClrMask,
  input  logic               statClrValid,
  input  logic [COND_W-1:0]  statClrMask,
  output logic [COND_W-1:0]  statusOut,
  output logic [COND_W-1:0]  enableOut,
  output logic [PLL_CNT-1:0] lockNow,
  output logic               irqOut
);
  strobe_t strobes;

  pll_lock_sync #(.WIDTH(PLL_CNT), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(lockIn), .syncOut(lockNow)
  );

  pll_irq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lockSync(lockNow),
    .enSetValid(enSetValid), .enSetMask(enSetMask),
    .enClrValid(enClrValid), .enClrMask(enClrMask),
    .statClrValid(statClrValid), .statClrMask(statClrMask),
    .strobes(strobes)
  );

  pll_irq_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .statusQ(statusOut), .enableQ(enableOut), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_pll_lock_irq.sv
module tb_pll_lock_irq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] lockIn = '0;
  logic       enSetValid = 1'b0, enClrValid = 1'b0, statClrValid = 1'b0;
  logic [5:0] enSetMask = '0, enClrMask = '0, statClrMask = '0;
  logic [5:0] statusOut, enableOut;
  logic [2:0] lockNow;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [5:0] st;
    logic [5:0] en;
    logic [2:0] lk;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t q[$];

  // Reference state, updated from the requirement rules.
  logic [5:0] stM = '0, enM = '0;
  logic [2:0] s1M = '0, lockM = '0, lastM = '0;

  always #10 clk = ~clk;

  pll_lock_irq dut (
    .clk(clk), .rstN(rstN), .lockIn(lockIn),
    .enSetValid(enSetValid), .enSetMask(enSetMask),
    .enClrValid(enClrValid), .enClrMask(enClrMask),
    .statClrValid(statClrValid), .statClrMask(statClrMask),
    .statusOut(statusOut), .enableOut(enableOut), .lockNow(lockNow), .irqOut(irqOut)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (statusOut !== e.st || enableOut !== e.en || lockNow !== e.lk || irqOut !== e.irq) begin
      fails++;
      $display("FAIL %s: got st=%b en=%b lk=%b irq=%b, expected st=%b en=%b lk=%b irq=%b",
               e.tag, statusOut, enableOut, lockNow, irqOut, e.st, e.en, e.lk, e.irq);
    end
  endtask

  // Driver: apply one cycle of stimulus, advance the model, push the expectation.
  task automatic cyc(input logic [2:0] lk, input logic [5:0] es, input logic [5:0] ec,
                     input logic [5:0] sc, input bit live, input string tag);
    logic [5:0] ev;
    lockIn       = lk;
    enSetMask    = es;  enSetValid   = live;
    enClrMask    = ec;  enClrValid   = live;
    statClrMask  = sc;  statClrValid = live;
    @(posedge clk);
    ev    = {~lockM & lastM, lockM & ~lastM};
    stM   = (stM & ~(live ? sc : 6'b0)) | ev;
    enM   = (enM | (live ? es : 6'b0)) & ~(live ? ec : 6'b0);
    lastM = lockM; lockM = s1M; s1M = lk;
    #1;
    q.push_back('{st: stM, en: enM, lk: lockM, irq: |(stM & enM), tag: tag});
    @(negedge clk);
  endtask

  // Monitor: compare one expectation per cycle, away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare('{st: 6'b0, en: 6'b0, lk: 3'b0, irq: 1'b0, tag: "R1 in reset"});
    rstN = 1'b1;
    compare('{st: 6'b0, en: 6'b0, lk: 3'b0, irq: 1'b0, tag: "R1 after reset"});

    for (int i = 0; i < 4; i++) cyc(3'b001, 0, 0, 0, 1, "R2 R3 R9 main gains lock");
    for (int i = 0; i < 4; i++) cyc(3'b000, 0, 0, 0, 1, "R4 main loses lock");
    for (int i = 0; i < 4; i++) cyc(3'b001, 0, 0, 0, 1, "R3 sticky relock");
    cyc(3'b001, 6'b000001, 0, 0, 1, "R5 R8 enable main gained");
    cyc(3'b001, 6'b001000, 0, 0, 1, "R5 enable main lost, others kept");
    cyc(3'b001, 0, 6'b000001, 0, 1, "R6 disable one bit");
    cyc(3'b001, 0, 0, 6'b001000, 1, "R7 R8 selective clear drops irq");
    cyc(3'b001, 6'b000010, 6'b000010, 0, 1, "R6 clear wins over set");
    cyc(3'b001, 6'b111111, 6'b111111, 6'b111111, 0, "R5 R7 masks ignored without strobe");
    cyc(3'b101, 0, 0, 0, 1, "R2 memory pll rises");
    cyc(3'b101, 0, 0, 0, 1, "R2 memory pll rises");
    cyc(3'b101, 0, 0, 6'b000101, 1, "R7 event wins over same-cycle clear");
    cyc(3'b101, 6'b111111, 0, 0, 1, "R8 all enabled");
    for (int i = 0; i < 4; i++) cyc(3'b010, 0, 0, 0, 1, "R3 R4 mixed edges");
    cyc(3'b010, 0, 0, 6'b111111, 1, "R7 R8 clear all");
    cyc(3'b010, 0, 6'b111111, 0, 1, "R6 disable all");
    cyc(3'b010, 0, 0, 0, 1, "R8 idle");
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule